// File: doc/BRIEF.md
# Host I/O to Local RAM Window Bridge

This block sits between a host I/O port and a local synchronous RAM. Host cycles whose address falls inside a fixed I/O range are compared against two windows. Each window has its own base address, a power-of-two size and a per-window offset into local RAM. When a window matches, the cycle becomes a RAM request. Separate read and write protection settings can block the lower half, the upper half or the whole of each window. Reads that are blocked or that match no window return 0xFF and never touch the RAM. Writes that are blocked are dropped and leave a sticky flag behind.

Host requests use a valid/ready handshake. A request is taken in any cycle where `h_valid` and `h_ready` are both high. The host must hold all request fields stable while `h_valid` is high and `h_ready` is low. Only one read is in flight at a time, so `h_ready` stays low from the accepted read until its response has been taken. Read responses use `r_valid`/`r_ready`. A response stays presented, with `r_data` unchanged, until `r_ready` is seen high. Writes produce no response. The configuration inputs are plain levels and should only change while the bridge is idle.

Top module: `h2r_bridge`

## Requirements
- R1: While reset is asserted and right after it: `h_ready`=1, `r_valid`=0, `ram_req`=0, `wr_blocked`=0.
- R2: Address decode. A window is active only when its enable bit in `cfg_ctrl` is set (bit 0 for window 0, bit 1 for window 1) and the I/O routing bit 4 is also set. The window base is the base byte times 16. The size is 16 << `attr[2:0]` bytes. A hit drives `ram_addr` = host address − window base + the window's local offset.
- R3: When the base is not a multiple of the window size, its low bits are ignored. For example, base byte 0x81 with a 256-byte window decodes as 0x800.
- R4: When both windows match an address, window 0 alone decides the RAM address and the protection that applies.
- R5: Write protection sits in `attr[5:4]`: 00 none, 01 lower half, 10 upper half, 11 whole window. A blocked write issues no RAM request and sets `wr_blocked`. The flag then stays set until reset.
- R6: Read protection sits in `attr[7:6]`, with the same encoding as R5. A blocked read issues no RAM request and returns 0xFF.
- R7: A read that matches no window returns 0xFF with no RAM request. A missed write is dropped with no RAM request and does not set `wr_blocked`.
- R8: A request is accepted at the edge where `h_valid`&&`h_ready`. Any RAM request is issued in that same cycle. The read response is raised at the second edge after acceptance. It stays stable while `r_ready` is low, and `h_ready` stays low until the response is taken.
- R9: Addresses outside RANGE_LO..RANGE_HI (default 0x800..0x9FF) never match, whatever the window settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ctrl | input | 8 | Bit 0/1: window enables; bit 4: I/O routing enable |
| cfg_base0 | input | 8 | Window 0 base address / 16 |
| cfg_base1 | input | 8 | Window 1 base address / 16 |
| cfg_attr0 | input | 8 | Window 0 size and protection |
| cfg_attr1 | input | 8 | Window 1 size and protection |
| cfg_loc0 | input | RAM_AW | Window 0 local RAM offset |
| cfg_loc1 | input | RAM_AW | Window 1 local RAM offset |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Bridge can accept a request |
| h_write | input | 1 | 1 = write, 0 = read |
| h_addr | input | HA_W | Host I/O address |
| h_wdata | input | 8 | Host write data |
| r_valid | output | 1 | Read response valid |
| r_ready | input | 1 | Host takes the response |
| r_data | output | 8 | Read response data |
| ram_req | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | RAM_AW | RAM word address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after the request |
| wr_blocked | output | 1 | Sticky flag for a protection-blocked write |

## Verification
A vector table first runs a typical two-window setup. The reads at both ends of each window show that the base subtraction and the local offset are correct. Writes followed by reads back show whether the data really reached RAM or was dropped, and addresses just outside the range separate a miss from an edge hit. Directed cases then change one setting at a time: a misaligned base, overlapping windows, each half-protection code for reads and for writes, disabled enables and a window placed outside the range. Each of these patterns sets one decision against its neighbours. Finally, a response held under back-pressure shows that the data stays stable and that no new request is accepted in the meantime.

// File: rtl/h2r_pkg.sv
package h2r_pkg;
  typedef enum logic [1:0] {
    PROT_NONE = 2'b00,
    PROT_LOW  = 2'b01,
    PROT_HIGH = 2'b10,
    PROT_ALL  = 2'b11
  } prot_e;

  // True when an access to the given half is refused under the code.
  function automatic logic prot_block(input logic [1:0] code, input logic upper);
    case (prot_e'(code))
      PROT_NONE: prot_block = 1'b0;
      PROT_LOW:  prot_block = ~upper;
      PROT_HIGH: prot_block = upper;
      default:   prot_block = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/h2r_win.sv
module h2r_win #(
  parameter int HA_W   = 16,
  parameter int WIN_AW = 12,
  parameter int RAM_AW = 11
) (
  input  logic              en,
  input  logic [WIN_AW-5:0] base,
  input  logic [2:0]        size_code,
  input  logic [HA_W-1:0]   addr,
  output logic              hit,
  output logic              upper,
  output logic [RAM_AW-1:0] off
);
  logic [WIN_AW-1:0] mask, half, base_al, a_lo;
  logic              hi_zero;

  always_comb begin
    mask    = ~({WIN_AW{1'b1}} << (int'(size_code) + 4));
    half    = WIN_AW'(1) << (int'(size_code) + 3);
    base_al = {base, 4'b0000} & ~mask;
    a_lo    = addr[WIN_AW-1:0];
    hi_zero = (addr[HA_W-1:WIN_AW] == '0);
    hit     = en & hi_zero & ((a_lo & ~mask) == base_al);
    upper   = |(a_lo & half);
    off     = RAM_AW'(a_lo & mask);
  end
endmodule

// File: rtl/h2r_sel.sv
module h2r_sel
  import h2r_pkg::*;
#(
  parameter int NWIN   = 2,
  parameter int RAM_AW = 11
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NWIN-1:0]             hit,
  input  logic [NWIN-1:0]             upper,
  input  logic [NWIN-1:0][RAM_AW-1:0] off,
  input  logic [NWIN-1:0][RAM_AW-1:0] loc,
  input  logic [NWIN-1:0][7:0]        attr,
  input  logic                        accept,
  input  logic                        is_wr,
  input  logic [7:0]                  wdata,
  output logic                        ram_req,
  output logic                        ram_we,
  output logic [RAM_AW-1:0]           ram_addr,
  output logic [7:0]                  ram_wdata,
  output logic                        wr_blk
);
  localparam int SEL_W = (NWIN > 1) ? $clog2(NWIN) : 1;
  logic [SEL_W-1:0] sel;
  logic             any, blk;

  // Lowest-numbered matching window wins.
  always_comb begin
    sel = '0;
    for (int i = NWIN - 1; i >= 0; i--)
      if (hit[i]) sel = SEL_W'(i);
    any = |hit;
    blk = is_wr ? prot_block(attr[sel][5:4], upper[sel])
                : prot_block(attr[sel][7:6], upper[sel]);
    ram_req   = accept & any & ~blk;
    ram_we    = is_wr;
    ram_addr  = off[sel] + loc[sel];
    ram_wdata = wdata;
    wr_blk    = accept & is_wr & any & blk;
  end

  // R7
  miss_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0) |-> !ram_req);
endmodule

// File: rtl/h2r_resp.sv
module h2r_resp (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_acc,
  input  logic       rd_ram,
  input  logic [7:0] ram_rdata,
  input  logic       r_ready,
  output logic       r_valid,
  output logic [7:0] r_data,
  output logic       busy
);
  logic pend, pend_ram;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      pend_ram <= 1'b0;
      r_valid  <= 1'b0;
      r_data   <= 8'hFF;
    end else begin
      if (pend) begin
        r_valid <= 1'b1;
        r_data  <= pend_ram ? ram_rdata : 8'hFF;
      end else if (r_valid && r_ready) begin
        r_valid <= 1'b0;
      end
      pend     <= rd_acc;
      pend_ram <= rd_ram;
    end
  end

  assign busy = pend | r_valid;

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data)));
  // R8
  rsp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(r_valid) |-> $past(rd_acc, 2));
endmodule

// File: rtl/h2r_bridge.sv
module h2r_bridge #(
  parameter int HA_W     = 16,
  parameter int WIN_AW   = 12,
  parameter int RAM_AW   = 11,
  parameter int RANGE_LO = 'h800,
  parameter int RANGE_HI = 'h9FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        cfg_ctrl,
  input  logic [7:0]        cfg_base0,
  input  logic [7:0]        cfg_base1,
  input  logic [7:0]        cfg_attr0,
  input  logic [7:0]        cfg_attr1,
  input  logic [RAM_AW-1:0] cfg_loc0,
  input  logic [RAM_AW-1:0] cfg_loc1,
  input  logic              h_valid,
  output logic              h_ready,
  input  logic              h_write,
  input  logic [HA_W-1:0]   h_addr,
  input  logic [7:0]        h_wdata,
  output logic              r_valid,
  input  logic              r_ready,
  output logic [7:0]        r_data,
  output logic              ram_req,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata,
  output logic              wr_blocked
);
  localparam int NWIN   = 2;
  localparam int BASE_W = WIN_AW - 4;
  localparam int ROUTE_BIT = 4;

  logic [NWIN-1:0][BASE_W-1:0] base;
  logic [NWIN-1:0][7:0]        attr;
  logic [NWIN-1:0][RAM_AW-1:0] loc, off;
  logic [NWIN-1:0]             hit, upper;
  logic in_rng, accept, wr_blk, busy;

  assign base   = {cfg_base1[BASE_W-1:0], cfg_base0[BASE_W-1:0]};
  assign attr   = {cfg_attr1, cfg_attr0};
  assign loc    = {cfg_loc1, cfg_loc0};
  assign in_rng = (int'(h_addr) >= RANGE_LO) && (int'(h_addr) <= RANGE_HI);
  assign h_ready = ~busy;
  assign accept  = h_valid & h_ready;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    h2r_win #(.HA_W(HA_W), .WIN_AW(WIN_AW), .RAM_AW(RAM_AW)) u_win (
      .en        (cfg_ctrl[i] & cfg_ctrl[ROUTE_BIT] & in_rng),
      .base      (base[i]),
      .size_code (attr[i][2:0]),
      .addr      (h_addr),
      .hit       (hit[i]),
      .upper     (upper[i]),
      .off       (off[i])
    );
  end

  h2r_sel #(.NWIN(NWIN), .RAM_AW(RAM_AW)) u_sel (
    .clk, .rst_n, .hit, .upper, .off, .loc, .attr, .accept,
    .is_wr (h_write), .wdata (h_wdata),
    .ram_req, .ram_we, .ram_addr, .ram_wdata, .wr_blk
  );

  h2r_resp u_resp (
    .clk, .rst_n,
    .rd_acc (accept & ~h_write),
    .rd_ram (ram_req & ~ram_we),
    .ram_rdata, .r_ready, .r_valid, .r_data, .busy
  );

  always_ff @(posedge clk) begin
    if (!rst_n) wr_blocked <= 1'b0;
    else if (wr_blk) wr_blocked <= 1'b1;
  end

  // R5
  blk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> wr_blocked);
  // R8
  req_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_req |-> (h_valid && h_ready));
  // R9
  range_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && ((int'(h_addr) < RANGE_LO) || (int'(h_addr) > RANGE_HI))) |-> !ram_req);
endmodule

// File: tb/h2r_bridge_test.sv
module h2r_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int RAM_AW = 11;
  localparam int DEPTH = 1 << RAM_AW;
  localparam logic [11:0] NONE = 12'hFFF;
  localparam int NVEC = 11;
  // {write, addr, wdata, expected RAM index or NONE}
  localparam logic [36:0] VEC [NVEC] = '{
    {1'b0, 16'h0800, 8'h00, 12'h000},   // R2 window 0 low edge
    {1'b0, 16'h08FF, 8'h00, 12'h0FF},   // R2 window 0 high edge
    {1'b0, 16'h0900, 8'h00, 12'h100},   // R2 window 1 with local offset
    {1'b0, 16'h09FF, 8'h00, 12'h1FF},   // R2
    {1'b1, 16'h0810, 8'hAB, 12'h010},   // R2 write lands
    {1'b0, 16'h0810, 8'h00, 12'h010},   // R2 read back
    {1'b1, 16'h0910, 8'hCD, NONE},      // R5 whole window write-protected
    {1'b0, 16'h0910, 8'h00, 12'h110},   // R5 old data kept
    {1'b0, 16'h0A00, 8'h00, NONE},      // R7 past range
    {1'b0, 16'h07FF, 8'h00, NONE},      // R7 below range
    {1'b1, 16'h0A00, 8'h11, NONE}       // R7 dropped write
  };

  logic clk = 0, rst_n = 0;
  logic [7:0] cfg_ctrl, cfg_base0, cfg_base1, cfg_attr0, cfg_attr1;
  logic [RAM_AW-1:0] cfg_loc0, cfg_loc1;
  logic h_valid = 0, h_write = 0, r_ready = 0;
  logic [15:0] h_addr = '0;
  logic [7:0] h_wdata = '0;
  logic h_ready, r_valid, ram_req, ram_we, wr_blocked;
  logic [7:0] r_data, ram_wdata, ram_rdata;
  logic [RAM_AW-1:0] ram_addr, last_addr;
  logic [7:0] mem [DEPTH];
  logic [7:0] shadow [DEPTH];
  int req_cnt = 0, total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  h2r_bridge uut (
    .clk, .rst_n, .cfg_ctrl, .cfg_base0, .cfg_base1, .cfg_attr0, .cfg_attr1,
    .cfg_loc0, .cfg_loc1, .h_valid, .h_ready, .h_write, .h_addr, .h_wdata,
    .r_valid, .r_ready, .r_data, .ram_req, .ram_we, .ram_addr, .ram_wdata,
    .ram_rdata, .wr_blocked
  );

  always @(posedge clk) begin
    if (ram_req) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      ram_rdata <= mem[ram_addr];
      req_cnt   <= req_cnt + 1;
      last_addr <= ram_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_a();
    cfg_ctrl = 8'h13;
    cfg_base0 = 8'h80; cfg_attr0 = 8'h04; cfg_loc0 = '0;
    cfg_base1 = 8'h90; cfg_attr1 = 8'h34; cfg_loc1 = 11'h100;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic do_op(input logic wr, input logic [15:0] a, input logic [7:0] d,
                       input logic [11:0] loc, input string req);
    int c0, n;
    logic [7:0] exp;
    while (!h_ready) @(negedge clk);
    c0 = req_cnt;
    h_valid = 1; h_write = wr; h_addr = a; h_wdata = d;
    @(negedge clk);
    h_valid = 0;
    chk((req_cnt - c0) == ((loc != NONE) ? 1 : 0), req, req_cnt - c0, (loc != NONE) ? 1 : 0);
    if (loc != NONE) chk(last_addr == loc[RAM_AW-1:0], req, last_addr, loc);
    if (wr) begin
      if (loc != NONE) shadow[loc[RAM_AW-1:0]] = d;
    end else begin
      n = 0;
      while (!r_valid && n < 5) begin @(negedge clk); n++; end
      exp = (loc == NONE) ? 8'hFF : shadow[loc[RAM_AW-1:0]];
      chk(r_valid && r_data == exp, req, r_data, exp);
      r_ready = 1;
      @(negedge clk);
      r_ready = 0;
    end
  endtask

  initial begin
    logic [7:0] held;
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
    cfg_a();
    repeat (2) @(negedge clk);
    // R1 during and after reset
    chk(h_ready && !r_valid && !ram_req && !wr_blocked, "R1", {h_ready, r_valid, ram_req, wr_blocked}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    chk(h_ready && !r_valid && !ram_req && !wr_blocked, "R1", {h_ready, r_valid, ram_req, wr_blocked}, 4'b1000);

    // R7 missed write leaves the flag clear
    do_op(1'b1, 16'h0A10, 8'h55, NONE, "R7");
    chk(!wr_blocked, "R7", wr_blocked, 0);

    for (int k = 0; k < NVEC; k++)
      do_op(VEC[k][36], VEC[k][35:20], VEC[k][19:12], VEC[k][11:0], "R2/R5/R7 vec");
    chk(wr_blocked, "R5", wr_blocked, 1);
    repeat (3) @(negedge clk);
    chk(wr_blocked, "R5 sticky", wr_blocked, 1);

    // R8 back-pressure
    do_reset();
    cfg_a();
    h_valid = 1; h_write = 0; h_addr = 16'h0801;
    @(negedge clk);
    h_valid = 0;
    while (!r_valid) @(negedge clk);
    held = r_data;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk(r_valid && r_data == held && !h_ready, "R8", r_data, held);
    end
    chk(held == shadow[1], "R8", held, shadow[1]);
    r_ready = 1;
    @(negedge clk);
    r_ready = 0;
    chk(!r_valid && h_ready, "R8", {r_valid, h_ready}, 2'b01);

    // R3 misaligned base
    cfg_base0 = 8'h81;
    do_op(1'b0, 16'h0805, 8'h00, 12'h005, "R3");

    // R4 overlap: window 0 covers 800h-FFFh and decides
    cfg_base0 = 8'h80; cfg_attr0 = 8'h07; cfg_loc0 = 11'h200;
    do_op(1'b0, 16'h0905, 8'h00, 12'h305, "R4");
    do_op(1'b1, 16'h0905, 8'h77, 12'h305, "R4");
    do_op(1'b0, 16'h0905, 8'h00, 12'h305, "R4");

    // R5 half write protection
    cfg_a();
    cfg_attr1 = 8'h14;
    do_op(1'b1, 16'h0910, 8'h21, NONE, "R5 low");
    do_op(1'b1, 16'h0990, 8'h22, 12'h190, "R5 low");
    cfg_attr1 = 8'h24;
    do_op(1'b1, 16'h0910, 8'h23, 12'h110, "R5 high");
    do_op(1'b1, 16'h0990, 8'h24, NONE, "R5 high");

    // R6 read protection
    cfg_attr1 = 8'h44;
    do_op(1'b0, 16'h0910, 8'h00, NONE, "R6 low");
    do_op(1'b0, 16'h0990, 8'h00, 12'h190, "R6 low");
    cfg_attr1 = 8'h84;
    do_op(1'b0, 16'h0910, 8'h00, 12'h110, "R6 high");
    do_op(1'b0, 16'h0990, 8'h00, NONE, "R6 high");
    cfg_attr1 = 8'hC4;
    do_op(1'b0, 16'h09F0, 8'h00, NONE, "R6 all");

    // R2 enables
    cfg_attr1 = 8'h04;
    cfg_ctrl = 8'h11;
    do_op(1'b0, 16'h0900, 8'h00, NONE, "R2 win1 off");
    cfg_ctrl = 8'h03;
    do_op(1'b0, 16'h0800, 8'h00, NONE, "R2 route off");

    // R9 window placed past the range
    cfg_ctrl = 8'h13; cfg_base0 = 8'hA0; cfg_attr0 = 8'h00;
    do_op(1'b0, 16'h0A00, 8'h00, NONE, "R9");
    do_op(1'b1, 16'h0A05, 8'h66, NONE, "R9");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule